// File: doc/BRIEF.md
# Buzzer Tone Generator with Envelope and One-Shot Sequencing

The block produces a square-wave tone for a piezo buzzer from a slow oscillator clock. It drives the tone on one output and its logical complement on a second output, so a buzzer can be driven differentially. Software configures it through four byte-wide registers: a clock-gate register, a control register (enable, mode, interval), a tone-period register and a duty register.

There are three working modes. Normal mode plays a continuous tone at the programmed duty. One-shot mode plays a burst that lasts one selected interval and then clears its own enable bit. Envelope mode fades the tone: starting at volume level 1 (widest pulse) it narrows the high time by one step per interval until level 8, where it stays until software clears the enable bit. Each tone period is a frame of 16 phases of `freq + 1` clock cycles each. The high time covers a whole number of those phases.

Top module: `buzzer_gen`

## Requirements
- R1: After reset every register reads 0 and both outputs are low.
- R2: Register map (address: contents): 0: gate bit in bit 0; 1: interval select in bits 5:4, mode in bits 3:2, enable in bit 0; 2: tone period code in bits 7:0; 3: duty code in bits 2:0. Unused bits read 0 even after being written 1.
- R3: While the gate bit is 0, both outputs stay low, even with enable set.
- R4: While sounding, the complementary output is the exact inverse of the buzzer output. Both outputs are low whenever enable is 0.
- R5: In normal mode (mode 0) the tone period is 16*(F+1) cycles for period code F. The buzzer output is high for (D+1)*(F+1) cycles of each period for duty code D. The tone keeps going until enable is written 0.
- R6: Interval select code S gives an interval of 512<<S clock cycles (15.63, 31.25, 62.5, 125 ms at 32.768 kHz).
- R7: In one-shot mode (mode 1), writing enable 1 sounds the outputs for exactly one interval. Then the enable bit reads back 0.
- R8: Writing enable 0 during a one-shot burst silences both outputs from the next cycle.
- R9: In envelope mode (mode 2), volume level L (1..8) gives a high time of (9-L)*(F+1) cycles per period. The level starts at 1 on the enable write, rises by one each interval, and stays at 8 until enable is written 0. A later write of enable 1 starts again at level 1.
- R10: Mode 3 is reserved and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bz_out | output | 1 | Buzzer tone |
| bz_out_n | output | 1 | Complement of the buzzer tone while sounding |

## Verification
The sequencer's state is seen directly at the outputs. A timer that drifts shows up as a one-shot burst that is longer or shorter than the interval, or as an enable bit that never clears. This appears in the burst cycle count at the end of the interval. A wrong volume index shows up within one tone period as the wrong number of high cycles. So the envelope is checked by counting high cycles in a window of one period in the middle of each step. A stuck phase counter or a missed reset on disable breaks the complementary pair at once, or leaves the outputs active while gated.

// File: rtl/buzzer_pkg.sv
package buzzer_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_ENVELOPE = 2'd2,
    MODE_RSVD     = 2'd3
  } bz_mode_e;

  localparam logic [1:0] ADR_GATE = 2'd0;
  localparam logic [1:0] ADR_CTRL = 2'd1;
  localparam logic [1:0] ADR_FREQ = 2'd2;
  localparam logic [1:0] ADR_DUTY = 2'd3;

  localparam int TONE_PHASES = 16;
  localparam int VOL_LEVELS  = 8;
  localparam int PH_W        = $clog2(TONE_PHASES) + 1;
  localparam int LVL_W       = $clog2(VOL_LEVELS);

  // interval length in clock cycles for interval select code
  function automatic int unsigned step_ticks(int unsigned base, logic [1:0] tsel);
    return base << tsel;
  endfunction

  // number of high phases for a software duty code
  function automatic logic [PH_W-1:0] duty_high(logic [LVL_W-1:0] d);
    return PH_W'(d) + PH_W'(1);
  endfunction

  // number of high phases for an envelope level index (0 = loudest)
  function automatic logic [PH_W-1:0] level_high(logic [LVL_W-1:0] idx);
    return PH_W'(VOL_LEVELS) - PH_W'(idx);
  endfunction

endpackage

// File: rtl/buzzer_regs.sv
module buzzer_regs
  import buzzer_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              en_clear,
  output logic              gate_on,
  output logic [1:0]        tsel,
  output bz_mode_e          mode,
  output logic              en,
  output logic [FREQ_W-1:0] freq,
  output logic [LVL_W-1:0]  duty
);

  logic ctrl_wr;
  assign ctrl_wr = we && (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_on <= 1'b0;
      tsel    <= 2'd0;
      mode    <= MODE_NORMAL;
      en      <= 1'b0;
      freq    <= '0;
      duty    <= '0;
    end else begin
      if (en_clear) en <= 1'b0;
      if (we) begin
        case (addr)
          ADR_GATE: gate_on <= wdata[0];
          ADR_CTRL: begin
            tsel <= wdata[5:4];
            mode <= bz_mode_e'(wdata[3:2]);
            en   <= wdata[0];
          end
          ADR_FREQ: freq <= wdata[FREQ_W-1:0];
          default:  duty <= wdata[LVL_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      ADR_GATE: rdata[0] = gate_on;
      ADR_CTRL: rdata = {2'b00, tsel, mode, 1'b0, en};
      ADR_FREQ: rdata[FREQ_W-1:0] = freq;
      default:  rdata[LVL_W-1:0] = duty;
    endcase
  end

  // R7: the sequencer's end-of-burst pulse clears enable unless software writes control
  p_oneshot_autoclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clear && !ctrl_wr) |=> !en);

endmodule

// File: rtl/buzzer_seq.sv
module buzzer_seq
  import buzzer_pkg::*;
#(
  parameter int BASE_TICKS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             en,
  input  bz_mode_e         mode,
  input  logic [1:0]       tsel,
  output logic             armed,
  output logic [LVL_W-1:0] lvl,
  output logic             step_tick,
  output logic             expire
);

  localparam int TW = $clog2(BASE_TICKS * 8);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(VOL_LEVELS - 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] limit;
  logic          runnable;

  assign limit     = TW'(step_ticks(BASE_TICKS, tsel) - 1);
  assign runnable  = en && (mode != MODE_RSVD);
  assign step_tick = ce && armed && runnable && (timer == limit);
  assign expire    = step_tick && (mode == MODE_ONESHOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      timer <= '0;
      lvl   <= '0;
    end else if (ce) begin
      if (!runnable) begin
        armed <= 1'b0;
        timer <= '0;
        lvl   <= '0;
      end else if (!armed) begin
        armed <= 1'b1;
        timer <= '0;
        lvl   <= '0;
      end else if (timer == limit) begin
        timer <= '0;
        if (mode == MODE_ENVELOPE && lvl != LAST_LVL) lvl <= lvl + 1'b1;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  // R9: an interval boundary in envelope mode advances the level by exactly one
  p_level_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && mode == MODE_ENVELOPE && lvl != LAST_LVL) |=> (lvl == $past(lvl) + 1'b1));

  // R9: the level never moves without an interval boundary while running
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && runnable && ce && !step_tick) |=> (lvl == $past(lvl)));

  // R4: dropping enable disarms the sequencer at the next active edge
  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !en) |=> !armed);

  // R6: interval timer never runs past the selected limit while tsel is steady
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(tsel)) |-> (timer <= limit));

endmodule

// File: rtl/buzzer_tone.sv
module buzzer_tone
  import buzzer_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FREQ_W-1:0] freq,
  input  logic [PH_W-1:0]   high_ph,
  output logic              wave
);

  localparam int CW = $clog2(TONE_PHASES);

  logic [FREQ_W-1:0] pre;
  logic [CW-1:0]     phase;
  logic              pre_wrap;

  assign pre_wrap = (pre >= freq);
  assign wave     = ({1'b0, phase} < high_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      phase <= '0;
    end else if (!run) begin
      pre   <= '0;
      phase <= '0;
    end else if (pre_wrap) begin
      pre   <= '0;
      phase <= phase + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R5: a fresh tone always begins in the high part of the frame
  p_wave_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && high_ph != '0) |-> wave);

  // R5: the phase only advances at the end of a prescaler run
  p_phase_pace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pre_wrap) |=> ($stable(phase) || !run));

endmodule

// File: rtl/buzzer_gen.sv
module buzzer_gen
  import buzzer_pkg::*;
#(
  parameter int BASE_TICKS = 512,
  parameter int FREQ_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bz_out,
  output logic       bz_out_n
);

  logic              gate_on;
  logic [1:0]        tsel;
  bz_mode_e          mode;
  logic              en;
  logic [FREQ_W-1:0] freq;
  logic [LVL_W-1:0]  duty;
  logic              armed;
  logic [LVL_W-1:0]  lvl;
  logic              step_tick;
  logic              expire;
  logic              active;
  logic              wave;
  logic [PH_W-1:0]   high_ph;

  buzzer_regs #(.FREQ_W(FREQ_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .en_clear (expire),
    .gate_on  (gate_on),
    .tsel     (tsel),
    .mode     (mode),
    .en       (en),
    .freq     (freq),
    .duty     (duty)
  );

  buzzer_seq #(.BASE_TICKS(BASE_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (gate_on),
    .en        (en),
    .mode      (mode),
    .tsel      (tsel),
    .armed     (armed),
    .lvl       (lvl),
    .step_tick (step_tick),
    .expire    (expire)
  );

  assign high_ph = (mode == MODE_ENVELOPE) ? level_high(lvl) : duty_high(duty);
  assign active  = gate_on && en && armed && (mode != MODE_RSVD);

  buzzer_tone #(.FREQ_W(FREQ_W)) u_tone (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .freq    (freq),
    .high_ph (high_ph),
    .wave    (wave)
  );

  assign bz_out   = active && wave;
  assign bz_out_n = active && !wave;

  // R4: the pair is never high together
  p_pair_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bz_out && bz_out_n));

  // R3: a closed gate keeps both outputs quiet
  p_gate_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |-> (!bz_out && !bz_out_n));

  // R10: reserved mode is silent
  p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD) |-> (!bz_out && !bz_out_n));

  // R7: a one-shot end pulse is followed by silence
  p_burst_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reg_we) |=> (!bz_out && !bz_out_n));

endmodule

// File: tb/buzzer_gen_bench.sv
module buzzer_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       bz_out;
  logic       bz_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  buzzer_gen u_buzzer_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bz_out    (bz_out),
    .bz_out_n  (bz_out_n)
  );

  function automatic int exp_duty_high(int d, int f);
    return (d + 1) * (f + 1);
  endfunction

  function automatic int exp_env_high(int step, int f);
    int lv;
    lv = (step > 7) ? 8 : step + 1;
    return (9 - lv) * (f + 1);
  endfunction

  function automatic int exp_ticks(int s);
    return 512 * (1 << s);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // counts cycles over a window: buzzer high, complement high, sounding, pair broken
  task automatic measure(int w, output int hi, output int lo, output int act, output int bad);
    hi = 0; lo = 0; act = 0; bad = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (bz_out) hi++;
      if (bz_out_n) lo++;
      if (bz_out || bz_out_n) act++;
      if (bz_out && bz_out_n) bad++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, hi, lo, act, bad, f, d, w, t;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 0);
    end
    measure(20, hi, lo, act, bad);
    check("R1 outputs low after reset", act, 0);

    // R2: read-back with unused bits masked
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 gate readback", v, 8'h01);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R2 control readback", v, 8'h3D);
    wr(2'd2, 8'hA5); rd(2'd2, v); check("R2 period readback", v, 8'hA5);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R2 duty readback", v, 8'h07);

    // R10: reserved mode with enable set stays silent
    measure(200, hi, lo, act, bad);
    check("R10 reserved mode silent", act, 0);
    wr(2'd1, 8'h00);

    // R5/R4: normal mode, random and corner settings
    for (int k = 0; k < 10; k++) begin
      if (k == 0) begin f = 0; d = 7; end
      else if (k == 1) begin f = 255; d = 0; end
      else begin f = $urandom % 16; d = $urandom % 8; end
      w = 16 * (f + 1);
      wr(2'd2, 8'(f));
      wr(2'd3, 8'(d));
      wr(2'd1, 8'h01);
      repeat (20) @(negedge clk);
      measure(w, hi, lo, act, bad);
      check("R5 normal high cycles", hi, exp_duty_high(d, f));
      check("R4 complement cycles", lo, w - exp_duty_high(d, f));
      check("R4 pair exclusive", bad, 0);
      if (k < 3) begin
        repeat (2000) @(negedge clk);
        measure(w, hi, lo, act, bad);
        check("R5 tone continues", hi, exp_duty_high(d, f));
      end
      wr(2'd1, 8'h00);
      measure(30, hi, lo, act, bad);
      check("R4 both low when disabled", act, 0);
    end

    // R3: gate closed
    f = 3; d = 2;
    wr(2'd2, 8'(f)); wr(2'd3, 8'(d));
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    measure(300, hi, lo, act, bad);
    check("R3 gated outputs low", act, 0);
    wr(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    measure(64, hi, lo, act, bad);
    check("R3 sounding after gate opens", act, 64);
    wr(2'd1, 8'h00);

    // R6/R7: one-shot length for every interval code
    for (int s = 0; s < 4; s++) begin
      t = exp_ticks(s);
      wr(2'd1, 8'((s << 4) | 8'h05));
      measure(t + 100, hi, lo, act, bad);
      check("R7 R6 one-shot length", act, t);
      rd(2'd1, v);
      check("R7 enable self-clears", v, (s << 4) | 8'h04);
    end

    // R8: early stop
    wr(2'd1, 8'h35);
    repeat (100) @(negedge clk);
    measure(16, hi, lo, act, bad);
    check("R8 burst sounding before stop", act, 16);
    wr(2'd1, 8'h34);
    measure(50, hi, lo, act, bad);
    check("R8 silent after early stop", act, 0);

    // R9: envelope levels, hold at level 8, restart
    f = $urandom % 4;
    w = 16 * (f + 1);
    t = exp_ticks(0);
    wr(2'd2, 8'(f));
    wr(2'd1, 8'h09);
    repeat (201) @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      measure(w, hi, lo, act, bad);
      check("R9 envelope level high cycles", hi, exp_env_high(j, f));
      check("R4 envelope complement", lo, w - exp_env_high(j, f));
      repeat (t - w) @(negedge clk);
    end
    rd(2'd1, v);
    check("R9 enable stays set in envelope", v, 8'h09);
    wr(2'd1, 8'h08);
    measure(20, hi, lo, act, bad);
    check("R9 envelope stopped", act, 0);
    wr(2'd1, 8'h09);
    repeat (201) @(negedge clk);
    measure(w, hi, lo, act, bad);
    check("R9 restart at level 1", hi, exp_env_high(0, f));

    // R6: envelope with interval code 1
    wr(2'd1, 8'h08);
    wr(2'd1, 8'h19);
    repeat (201 + 512) @(negedge clk);
    measure(w, hi, lo, act, bad);
    check("R6 envelope still level 1 at half interval", hi, exp_env_high(0, f));
    repeat (exp_ticks(1) - 512 - w) @(negedge clk);
    measure(w, hi, lo, act, bad);
    check("R6 envelope level 2 after one interval", hi, exp_env_high(1, f));
    wr(2'd1, 8'h00);

    finish_run();
  end

endmodule